// File: doc/BRIEF.md
# Three-wire serial command receiver

This block is the device side of a three-wire serial link (chip select, serial clock, data in) in front of a 16-bit-wide nonvolatile memory model. It samples the three link wires with the system clock and waits for a start bit. It then collects a two-bit opcode, an eight-bit address and, where the instruction carries them, sixteen data bits. Once every required bit has arrived, it presents one decoded command to the core for a single cycle. The command carries the levels of the protect-select pin and the program-enable pin. The protect-select level tells the core to apply the protect-register version of the instruction.

For reads, the block fetches words from an external synchronous RAM port that has one cycle of latency. It drives them on the serial output behind a leading zero bit. It keeps streaming the following words for as long as chip select stays high. After a programming instruction, the block shows the ready/busy level from the timing logic on the serial output once chip select is raised again. Outside read data and status, the output enable stays low.

Top module: `mw_cmd_rx`

## Requirements
- R1: Before a start bit, activity on the link has no effect. This holds for serial clocks taken with chip select low, and for clocks with chip select high and data in low. The start bit is the first rising serial clock at which chip select and data in are both high.
- R2: After the start bit, the opcode (2 bits) and the address (8 bits) are shifted in MSB first on rising serial clocks. When the instruction carries data, 16 data bits follow, also MSB first. They appear on `cmd_addr_o` and `cmd_data_o`. `cmd_data_o` is 0 for instructions without data.
- R3: `cmd_op_o` encodes the instruction. Opcode 10 gives 0 (read), 01 gives 1 (write) and 11 gives 2 (erase). Opcode 00 is decoded by address bits [7:6]: 11 gives 3 (enable), 10 gives 4 (erase-all), 01 gives 5 (write-all) and 00 gives 6 (disable).
- R4: The protect-select and program-enable levels at the last address bit appear on `cmd_pre_o` and `cmd_pe_o`. With protect-select high, write and write-all take no data bits and complete after the address.
- R5: `cmd_valid_o` is a one-cycle pulse, raised only once every required bit of a frame has arrived. A frame cut short by chip select falling produces no command.
- R6: A read raises `rd_req_o` with the frame's address. The output enable is raised and DO drives a 0 dummy bit. Each following rising serial clock then drives the next data bit, from D15 down to D0.
- R7: While chip select stays high, the rising serial clock after D0 drives the MSB of the next word. The read address advances by one and wraps from 255 to 0.
- R8: `do_oe_o` is low after reset and outside read output and status output. It drops after chip select falls.
- R9: After write, erase, erase-all or write-all, the block drives DO as the inverse of `busy_i` on the next rise of chip select. The same holds for the disable code with protect-select high. Status ends at the next start bit or when chip select falls. Other instructions give no status.
- R10: After a non-read instruction completes, further clocks with data in low have no effect. A later start bit within the same chip-select period begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| pre_i | input | 1 | Protect-register select pin |
| pe_i | input | 1 | Program-enable pin |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 3 | Decoded instruction code |
| cmd_addr_o | output | 8 | Command address |
| cmd_data_o | output | 16 | Command write data |
| cmd_pre_o | output | 1 | Protect-select level of the command |
| cmd_pe_o | output | 1 | Program-enable level of the command |
| rd_req_o | output | 1 | Read request to the RAM port |
| rd_addr_o | output | 8 | Read address |
| rd_data_i | input | 16 | Read data, valid one cycle after the request |
| busy_i | input | 1 | Programming in progress |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for DO |

## Verification
The hardest situation to reach is the word boundary of a sequential read. The next word has to be fetched inside the serial period of bit D0 and then appear without a dummy bit, and it has to wrap from the top address back to zero. The stimulus starts a read at address 254 and clocks out three full words under one chip-select period, so it crosses both the word boundary and the wrap. Status display is reached by raising chip select again after a programming frame while the bench toggles `busy_i`. It is then ended once by a new start bit and once by chip select falling.

// File: rtl/mw_cmd_rx.sv
module mw_cmd_rx #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sck_i,
  input  logic              di_i,
  input  logic              pre_i,
  input  logic              pe_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              cmd_pre_o,
  output logic              cmd_pe_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              busy_i,
  output logic              do_o,
  output logic              do_oe_o
);

  localparam int HDR_BITS = 2 + ADDR_W;
  localparam int FRM_BITS = HDR_BITS + DATA_W;
  localparam int SH_W     = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W    = $clog2(FRM_BITS + 1);
  localparam int BIT_W    = $clog2(DATA_W);

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_EN    = 3'd3;
  localparam logic [2:0] OP_ERALL = 3'd4;
  localparam logic [2:0] OP_WRALL = 3'd5;
  localparam logic [2:0] OP_DIS   = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_READ} st_t;

  logic [1:0] cs_m, sck_m, di_m, pre_m, pe_m;
  logic       cs_d, sck_d;
  logic       cs_s, sck_s, di_s, pre_s, pe_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_m <= '0; sck_m <= '0; di_m <= '0; pre_m <= '0; pe_m <= '0;
      cs_d <= 1'b0; sck_d <= 1'b0;
    end else begin
      cs_m  <= {cs_m[0], cs_i};
      sck_m <= {sck_m[0], sck_i};
      di_m  <= {di_m[0], di_i};
      pre_m <= {pre_m[0], pre_i};
      pe_m  <= {pe_m[0], pe_i};
      cs_d  <= cs_m[1];
      sck_d <= sck_m[1];
    end
  end

  assign cs_s  = cs_m[1];
  assign sck_s = sck_m[1];
  assign di_s  = di_m[1];
  assign pre_s = pre_m[1];
  assign pe_s  = pe_m[1];

  wire sck_rise = sck_s & ~sck_d;
  wire cs_rise  = cs_s & ~cs_d;

  function automatic logic [2:0] decode(input logic [1:0] opc, input logic [1:0] sub);
    case (opc)
      2'b10:   decode = OP_READ;
      2'b01:   decode = OP_WRITE;
      2'b11:   decode = OP_ERASE;
      default: case (sub)
        2'b11:   decode = OP_EN;
        2'b10:   decode = OP_ERALL;
        2'b01:   decode = OP_WRALL;
        default: decode = OP_DIS;
      endcase
    endcase
  endfunction

  function automatic logic is_prog(input logic [2:0] op, input logic pre);
    is_prog = (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_ERALL) ||
              (op == OP_WRALL) || (pre && op == OP_DIS);
  endfunction

  st_t               st;
  logic [CNT_W-1:0]  bcnt;
  logic [SH_W-2:0]   sh;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pre_q, pe_q;
  logic [DATA_W-1:0] obuf;
  logic [BIT_W-1:0]  ocnt;
  logic              dummy, do_q, rd_on, load_pend, stat_armed, stat_show;

  wire [SH_W-1:0]   sh_n   = {sh, di_s};
  wire [CNT_W-1:0]  bcnt_n = bcnt + CNT_W'(1);
  wire [ADDR_W-1:0] hdr_a  = sh_n[ADDR_W-1:0];
  wire [2:0]        hdr_op = decode(sh_n[HDR_BITS-1 -: 2], hdr_a[ADDR_W-1 -: 2]);
  wire              hdr_dat = !pre_s && (hdr_op == OP_WRITE || hdr_op == OP_WRALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0;
      op_q <= '0; addr_q <= '0; pre_q <= 1'b0; pe_q <= 1'b0;
      cmd_valid_o <= 1'b0; cmd_op_o <= '0; cmd_addr_o <= '0; cmd_data_o <= '0;
      cmd_pre_o <= 1'b0; cmd_pe_o <= 1'b0;
      rd_req_o <= 1'b0; rd_addr_o <= '0; load_pend <= 1'b0; obuf <= '0;
      ocnt <= '0; dummy <= 1'b0; do_q <= 1'b0; rd_on <= 1'b0;
      stat_armed <= 1'b0; stat_show <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      rd_req_o    <= 1'b0;
      load_pend   <= rd_req_o;
      if (load_pend) obuf <= rd_data_i;
      if (!cs_s) begin
        st        <= S_IDLE;
        rd_on     <= 1'b0;
        stat_show <= 1'b0;
      end else begin
        if (cs_rise && stat_armed) stat_show <= 1'b1;
        case (st)
          S_IDLE: if (sck_rise && di_s) begin
            st         <= S_SHIFT;
            bcnt       <= '0;
            stat_armed <= 1'b0;
            stat_show  <= 1'b0;
          end
          S_SHIFT: if (sck_rise) begin
            sh   <= sh_n[SH_W-2:0];
            bcnt <= bcnt_n;
            if (bcnt_n == CNT_W'(HDR_BITS)) begin
              op_q <= hdr_op; addr_q <= hdr_a; pre_q <= pre_s; pe_q <= pe_s;
              if (!hdr_dat) begin
                cmd_valid_o <= 1'b1;
                cmd_op_o    <= hdr_op;
                cmd_addr_o  <= hdr_a;
                cmd_data_o  <= '0;
                cmd_pre_o   <= pre_s;
                cmd_pe_o    <= pe_s;
                if (is_prog(hdr_op, pre_s)) stat_armed <= 1'b1;
                if (hdr_op == OP_READ) begin
                  st        <= S_READ;
                  rd_req_o  <= 1'b1;
                  rd_addr_o <= hdr_a;
                  rd_on     <= 1'b1;
                  dummy     <= 1'b1;
                  do_q      <= 1'b0;
                end else begin
                  st <= S_IDLE;
                end
              end
            end else if (bcnt_n == CNT_W'(FRM_BITS)) begin
              cmd_valid_o <= 1'b1;
              cmd_op_o    <= op_q;
              cmd_addr_o  <= addr_q;
              cmd_data_o  <= sh_n[DATA_W-1:0];
              cmd_pre_o   <= pre_q;
              cmd_pe_o    <= pe_q;
              stat_armed  <= 1'b1;
              st          <= S_IDLE;
            end
          end
          S_READ: if (sck_rise) begin
            if (dummy || ocnt == '0) begin
              dummy <= 1'b0;
              do_q  <= obuf[DATA_W-1];
              ocnt  <= BIT_W'(DATA_W - 1);
            end else begin
              do_q <= obuf[ocnt - BIT_W'(1)];
              ocnt <= ocnt - BIT_W'(1);
              if (ocnt == BIT_W'(1)) begin
                rd_req_o  <= 1'b1;
                rd_addr_o <= rd_addr_o + ADDR_W'(1);
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign do_oe_o = rd_on | stat_show;
  assign do_o    = rd_on ? do_q : ~busy_i;

  a_r8_oe_off_after_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !do_oe_o);
  a_r5_valid_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  a_r5_valid_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(cs_s));
  a_r6_dummy_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_on) |-> (!do_o && rd_req_o));
  a_r7_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

endmodule

// File: tb/test_mw_cmd_rx.sv
module test_mw_cmd_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0, pre = 1'b0, pe = 1'b0, busy = 1'b0;
  logic        cmd_valid, cpre, cpe, rd_req, dout, doe;
  logic [2:0]  cop;
  logic [7:0]  caddr, rd_addr;
  logic [15:0] cdata;
  logic [15:0] rd_data = '0;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [28:0] expq[$];

  always #10 clk = ~clk;

  mw_cmd_rx i_mw_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
    .pre_i(pre), .pe_i(pe), .cmd_valid_o(cmd_valid), .cmd_op_o(cop),
    .cmd_addr_o(caddr), .cmd_data_o(cdata), .cmd_pre_o(cpre), .cmd_pe_o(cpe),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .busy_i(busy), .do_o(dout), .do_oe_o(doe));

  function automatic logic [15:0] memf(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= memf(rd_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmd_valid) begin
    logic [28:0] got;
    got = {cop, caddr, cdata, cpre, cpe};
    if (expq.size() == 0) chk(1'b0, "R5 unexpected command", {3'b0, got}, 32'h0);
    else begin
      logic [28:0] e;
      e = expq.pop_front();
      chk(got == e, "R2 R3 R4 command fields", {3'b0, got}, {3'b0, e});
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic sbit(input logic b); di = b; wt(5); sck = 1'b1; wt(5); sck = 1'b0; endtask
  task automatic push(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d, input logic p, input logic e);
    expq.push_back({op, a, d, p, e});
  endtask
  task automatic send(input logic [1:0] opc, input logic [7:0] a, input logic [15:0] d,
                      input bit withd, input logic p, input logic e);
    pre = p; pe = e;
    sbit(1'b1);
    for (int i = 1; i >= 0; i--) sbit(opc[i]);
    for (int i = 7; i >= 0; i--) sbit(a[i]);
    if (withd) for (int i = 15; i >= 0; i--) sbit(d[i]);
    di = 1'b0;
  endtask
  task automatic csdn; wt(5); cs = 1'b0; wt(8); endtask
  task automatic csup; cs = 1'b1; wt(6); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wt(4); rst_n = 1'b1; wt(4);
    chk(!doe && !cmd_valid, "R8 reset state", {doe, cmd_valid}, 0);

    // R1: noise before start
    sbit(1'b1); sbit(1'b1); sbit(0);
    csup; sbit(0); sbit(0); sbit(0);
    chk(!doe && expq.size() == 0, "R1 no effect before start", doe, 0);
    push(3'd3, 8'hC5, 16'h0, 1'b0, 1'b1);
    send(2'b00, 8'hC5, 16'h0, 0, 1'b0, 1'b1);
    csdn;

    // R3 write and R9 status
    csup; push(3'd1, 8'h3C, 16'hBEEF, 1'b0, 1'b1);
    send(2'b01, 8'h3C, 16'hBEEF, 1, 1'b0, 1'b1); csdn;
    busy = 1'b1; csup;
    chk(doe && !dout, "R9 status busy", {doe, dout}, 2'b10);
    busy = 1'b0; wt(2);
    chk(doe && dout, "R9 status ready", {doe, dout}, 2'b11);
    cs = 1'b0; wt(6);
    chk(!doe, "R8 status off on cs low", doe, 0);

    csup; push(3'd2, 8'h81, 16'h0, 1'b0, 1'b1); send(2'b11, 8'h81, 16'h0, 0, 1'b0, 1'b1); csdn;
    csup; push(3'd4, 8'h80, 16'h0, 1'b0, 1'b1);
    pre = 1'b0; sbit(1'b1);
    chk(!doe, "R9 status ends at start bit", doe, 0);
    for (int i = 1; i >= 0; i--) sbit(1'b0);
    for (int i = 7; i >= 0; i--) sbit(i == 7);
    di = 1'b0; csdn;
    csup; push(3'd5, 8'h40, 16'h1234, 1'b0, 1'b1); send(2'b00, 8'h40, 16'h1234, 1, 1'b0, 1'b1); csdn;
    csup; push(3'd6, 8'h00, 16'h0, 1'b0, 1'b0); send(2'b00, 8'h00, 16'h0, 0, 1'b0, 1'b0); csdn;
    csup;
    chk(!doe, "R9 no status after disable", doe, 0);
    cs = 1'b0; wt(8);

    // R4: protect-select write takes no data
    csup; push(3'd1, 8'h20, 16'h0, 1'b1, 1'b1);
    send(2'b01, 8'h20, 16'h0, 0, 1'b1, 1'b1);
    chk(expq.size() == 0, "R4 protect write done after address", expq.size(), 0);
    csdn; pre = 1'b0;

    // R5: aborted frames
    csup; sbit(1'b1); sbit(1'b1); sbit(1'b0);
    for (int i = 0; i < 4; i++) sbit(1'b1);
    csdn;
    csup; sbit(1'b1); sbit(1'b0); sbit(1'b1);
    for (int i = 0; i < 8; i++) sbit(1'b0);
    for (int i = 0; i < 10; i++) sbit(1'b1);
    csdn;
    chk(expq.size() == 0, "R5 aborted frames give nothing", expq.size(), 0);

    // R10: extra clocks then a second frame under one chip select
    csup; push(3'd3, 8'hC0, 16'h0, 1'b0, 1'b1); send(2'b00, 8'hC0, 16'h0, 0, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) sbit(1'b0);
    push(3'd6, 8'h11, 16'h0, 1'b0, 1'b1); send(2'b00, 8'h11, 16'h0, 0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) sbit(1'b0);
    csdn;
    chk(expq.size() == 0, "R10 both frames seen once", expq.size(), 0);

    // R6 / R7: sequential read with wrap
    csup; push(3'd0, 8'hFE, 16'h0, 1'b0, 1'b0);
    send(2'b10, 8'hFE, 16'h0, 0, 1'b0, 1'b0);
    chk(doe && !dout, "R6 dummy zero", {doe, dout}, 2'b10);
    for (int w = 0; w < 3; w++) begin
      logic [15:0] word;
      logic [7:0] a;
      word = '0;
      a = 8'hFE + 8'(w);
      for (int b = 15; b >= 0; b--) begin
        sbit(1'b0);
        word = {word[14:0], dout};
      end
      chk(word == memf(a), "R6 R7 read word", word, memf(a));
    end
    chk(doe, "R8 oe during read", doe, 1);
    cs = 1'b0; wt(6);
    chk(!doe, "R8 oe drops after read", doe, 0);

    // R4: protect-register read
    csup; push(3'd0, 8'h07, 16'h0, 1'b1, 1'b0);
    send(2'b10, 8'h07, 16'h0, 0, 1'b1, 1'b0);
    begin
      logic [15:0] word;
      word = '0;
      for (int b = 15; b >= 0; b--) begin
        sbit(1'b0);
        word = {word[14:0], dout};
      end
      chk(word == memf(8'h07), "R4 R6 protect read word", word, memf(8'h07));
    end
    csdn; pre = 1'b0;

    chk(expq.size() == 0, "R5 all commands seen", expq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule